// File: doc/BRIEF.md
# Thermometer-to-Binary Sample Encoder with Pseudo-Random Test Pattern

This block sits behind a bank of flash comparators. On every fast sample clock it turns a 15-bit thermometer vector into a 4-bit binary sample. It does this by counting the ones in the vector, so an isolated bubble in the code costs at most one code step and never a large jump.

A single pattern-enable input switches every output lane between two sources. When the enable is low, the lanes carry the encoded sample. When it is high, they carry a pseudo-random test pattern, which downstream deserializers use to find the word alignment of the parallel interface. The pattern comes from a 7-stage feedback shift register that advances four positions per clock, so each output word holds four consecutive sequence bits. The output word is registered, and a valid flag reports when it carries meaningful data.

Top module: `therm_prbs_encoder`

## Requirements
- R1: With pattern_en_i low, sample_o one cycle later equals the number of ones in therm_i, read as an unsigned binary number with bit 3 as the MSB. The value is limited to 15.
- R2: Ones need not be contiguous. A vector with bubbles encodes to its ones count, so 15'h005F gives 6 and 15'h7FFE gives 14.
- R3: A new word is produced on every clock edge with one cycle of latency. The output after edge n depends only on the inputs sampled at edge n.
- R4: At an edge where rst_n is low, sample_o becomes 0 and sample_vld_o becomes 0. From the first edge with rst_n high onward, sample_vld_o is 1.
- R5: With pattern_en_i high, sample_o carries the bit sequence q defined by q[t] = q[t-7] XOR q[t-6], and therm_i has no effect.
- R6: Each pattern word carries four consecutive sequence bits. The earliest bit is on bit 0 and the latest on bit 3.
- R7: Whenever the enable is low, or reset is active, the seven history bits are reloaded to all ones. The first pattern word after a start is therefore 4'b0000, and the second is 4'b0100.
- R8: When the enable drops, encoding resumes on the next word. When the enable rises again, the pattern restarts from the all-ones history, not from where it stopped.
- R9: While rst_n is low, therm_i and pattern_en_i have no effect on the outputs.
- R10: Words 127 apart in an uninterrupted pattern run are equal, because the sequence is maximal-length with period 127.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| therm_i | input | 15 | Thermometer code from the comparator bank |
| pattern_en_i | input | 1 | 1 selects the test pattern, 0 selects the encoded sample |
| sample_o | output | 4 | Registered sample or pattern word |
| sample_vld_o | output | 1 | High once the output holds a word produced out of reset |

## Verification
The bench builds the block with its default 15-bit thermometer input and 4-bit word. This keeps the input space small enough to apply every one of the 32768 input vectors in turn, bubbles included, and compare each result with a ones count computed in the bench. With the 7-stage register and four bits per word, a full 127-word period fits in a short run. Two periods are captured, so the bench can check the recurrence word by word and compare each word with the one 127 words later. It also checks the restart from the all-ones history after the enable drops and after a reset taken in the middle of a run.

// File: rtl/tpe_pkg.sv
// Shared constants and types for the thermometer encoder with test pattern.
// Assumes nothing beyond SystemVerilog-2017 packages.
package tpe_pkg;
    localparam int unsigned DEF_THERM_W  = 15;
    localparam int unsigned DEF_SAMPLE_W = 4;
    localparam int unsigned DEF_LFSR_LEN = 7;
    localparam int unsigned DEF_TAP_HI   = 7;
    localparam int unsigned DEF_TAP_LO   = 6;
    localparam logic [6:0]  DEF_SEED     = 7'h7F;

    typedef enum logic {
        SRC_CODE    = 1'b0,
        SRC_PATTERN = 1'b1
    } src_sel_e;
endpackage

// File: rtl/tpe_ones_count.sv
// Counts the ones in a thermometer vector and limits the count to the
// largest value an OUT_W-bit word holds. Purely combinational.
// Assumes: THERM_W >= 1, OUT_W >= 1.
module tpe_ones_count #(
    parameter int unsigned THERM_W = 15,
    parameter int unsigned OUT_W   = 4
) (
    input  logic [THERM_W-1:0] therm_i,
    output logic [OUT_W-1:0]   code_o
);
    localparam int unsigned CNT_W   = $clog2(THERM_W + 1);
    localparam int unsigned SAT_MAX = (1 << OUT_W) - 1;

    logic [CNT_W-1:0] count;

    // Sum every comparator bit; bubbles simply add their weight of one.
    always_comb begin
        count = '0;
        for (int i = 0; i < THERM_W; i++) begin
            count = count + CNT_W'(therm_i[i]);
        end
    end

    generate
        if (THERM_W > SAT_MAX) begin : g_sat
            // Clamp counts that the output word cannot hold.
            always_comb begin
                if (count > CNT_W'(SAT_MAX)) code_o = OUT_W'(SAT_MAX);
                else                          code_o = OUT_W'(count);
            end
        end else begin : g_fit
            // Every possible count fits; pass it through.
            always_comb code_o = OUT_W'(count);
        end
    endgenerate
endmodule

// File: rtl/tpe_lfsr_steps.sv
// Advances a Fibonacci shift register STEPS positions in one cycle.
// The feedback is the XOR of stages TAP_HI and TAP_LO (1-based), shifted
// into stage 1. bits_o[k] is the k-th feedback bit, earliest in bit 0.
// Combinational. Assumes LEN >= 2 and TAP_LO < TAP_HI <= LEN.
module tpe_lfsr_steps #(
    parameter int unsigned LEN    = 7,
    parameter int unsigned TAP_HI = 7,
    parameter int unsigned TAP_LO = 6,
    parameter int unsigned STEPS  = 4
) (
    input  logic [LEN-1:0]   state_i,
    output logic [STEPS-1:0] bits_o,
    output logic [LEN-1:0]   state_o
);
    logic [LEN-1:0] walk;
    logic           fb;

    // Unroll STEPS single-bit shifts, collecting each new feedback bit.
    always_comb begin
        walk   = state_i;
        bits_o = '0;
        fb     = 1'b0;
        for (int k = 0; k < STEPS; k++) begin
            fb        = walk[TAP_HI-1] ^ walk[TAP_LO-1];
            bits_o[k] = fb;
            walk      = {walk[LEN-2:0], fb};
        end
        state_o = walk;
    end
endmodule

// File: rtl/tpe_pattern_gen.sv
// Test-pattern source: holds the shift-register state and offers one
// word of WORD_W fresh sequence bits per cycle while run_i is high.
// The state returns to SEED during reset or whenever run_i is low.
// Assumes: SEED is nonzero.
module tpe_pattern_gen #(
    parameter int unsigned    LEN    = 7,
    parameter int unsigned    TAP_HI = 7,
    parameter int unsigned    TAP_LO = 6,
    parameter int unsigned    WORD_W = 4,
    parameter logic [LEN-1:0] SEED   = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    output logic [WORD_W-1:0] word_o
);
    logic [LEN-1:0] state_q;
    logic [LEN-1:0] state_nxt;

    tpe_lfsr_steps #(
        .LEN    (LEN),
        .TAP_HI (TAP_HI),
        .TAP_LO (TAP_LO),
        .STEPS  (WORD_W)
    ) steps_i (
        .state_i (state_q),
        .bits_o  (word_o),
        .state_o (state_nxt)
    );

    // Hold the seed while idle, else advance one word's worth of steps.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) state_q <= SEED;
        else                  state_q <= state_nxt;
    end
endmodule

// File: rtl/therm_prbs_encoder.sv
// Top level: a ones-count encoder and a test-pattern source feed a
// 2-to-1 selector on each output lane, followed by the output register.
// One word per clock, one cycle of latency, synchronous active-low reset.
// Assumes the thermometer input is already synchronous to clk.
module therm_prbs_encoder #(
    parameter int unsigned THERM_W  = tpe_pkg::DEF_THERM_W,
    parameter int unsigned SAMPLE_W = tpe_pkg::DEF_SAMPLE_W,
    parameter int unsigned LFSR_LEN = tpe_pkg::DEF_LFSR_LEN,
    parameter int unsigned TAP_HI   = tpe_pkg::DEF_TAP_HI,
    parameter int unsigned TAP_LO   = tpe_pkg::DEF_TAP_LO,
    parameter logic [LFSR_LEN-1:0] SEED = tpe_pkg::DEF_SEED
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [THERM_W-1:0]  therm_i,
    input  logic                pattern_en_i,
    output logic [SAMPLE_W-1:0] sample_o,
    output logic                sample_vld_o
);
    import tpe_pkg::*;

    logic [SAMPLE_W-1:0] code_w;
    logic [SAMPLE_W-1:0] pat_w;
    logic [SAMPLE_W-1:0] lane_w;
    logic [SAMPLE_W-1:0] sample_q;
    logic                vld_q;
    src_sel_e            src_sel;

    tpe_ones_count #(
        .THERM_W (THERM_W),
        .OUT_W   (SAMPLE_W)
    ) enc_i (
        .therm_i (therm_i),
        .code_o  (code_w)
    );

    tpe_pattern_gen #(
        .LEN    (LFSR_LEN),
        .TAP_HI (TAP_HI),
        .TAP_LO (TAP_LO),
        .WORD_W (SAMPLE_W),
        .SEED   (SEED)
    ) pat_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (pattern_en_i),
        .word_o (pat_w)
    );

    // Source selection shared by all lanes.
    always_comb src_sel = pattern_en_i ? SRC_PATTERN : SRC_CODE;

    generate
        for (genvar l = 0; l < SAMPLE_W; l++) begin : g_lane
            // Per-lane selector between pattern bit and encoded bit.
            always_comb lane_w[l] = (src_sel == SRC_PATTERN) ? pat_w[l] : code_w[l];
        end
    endgenerate

    // Output register and valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_q <= '0;
            vld_q    <= 1'b0;
        end else begin
            sample_q <= lane_w;
            vld_q    <= 1'b1;
        end
    end

    assign sample_o     = sample_q;
    assign sample_vld_o = vld_q;
endmodule

// File: rtl/therm_prbs_encoder_chk.sv
// Property checker for therm_prbs_encoder, attached through bind.
// Observes ports only and keeps its own run-length history.
module therm_prbs_encoder_chk #(
    parameter int unsigned THERM_W  = 15,
    parameter int unsigned SAMPLE_W = 4,
    parameter int unsigned LFSR_LEN = 7,
    parameter int unsigned TAP_HI   = 7,
    parameter int unsigned TAP_LO   = 6,
    parameter logic [LFSR_LEN-1:0] SEED = '1
) (
    input logic                clk,
    input logic                rst_n,
    input logic [THERM_W-1:0]  therm_i,
    input logic                pattern_en_i,
    input logic [SAMPLE_W-1:0] sample_o,
    input logic                sample_vld_o
);
    localparam int unsigned SAT_MAX = (1 << SAMPLE_W) - 1;

    function automatic logic [SAMPLE_W-1:0] limited_count(input logic [THERM_W-1:0] v);
        int unsigned n = $countones(v);
        if (n > SAT_MAX) n = SAT_MAX;
        return SAMPLE_W'(n);
    endfunction

    function automatic logic [SAMPLE_W-1:0] seed_word();
        logic [LFSR_LEN-1:0] h = SEED;
        logic [SAMPLE_W-1:0] w = '0;
        for (int k = 0; k < SAMPLE_W; k++) begin
            w[k] = h[TAP_HI-1] ^ h[TAP_LO-1];
            h    = {h[LFSR_LEN-2:0], w[k]};
        end
        return w;
    endfunction

    logic [1:0]          run_len;
    logic [SAMPLE_W-1:0] prev1, prev2;
    logic [3*SAMPLE_W-1:0] hist;

    // Count consecutive pattern words produced in one uninterrupted run.
    always_ff @(posedge clk) begin
        if (!rst_n || !pattern_en_i) run_len <= 2'd0;
        else if (run_len != 2'd3)    run_len <= run_len + 2'd1;
    end

    // Keep the two previous output words.
    always_ff @(posedge clk) begin
        prev1 <= sample_o;
        prev2 <= prev1;
    end

    assign hist = {sample_o, prev1, prev2};

    AST_VLD_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> sample_vld_o); // R4

    AST_INVALID_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld_o |-> sample_o == '0); // R4

    AST_ENCODE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(pattern_en_i) |-> sample_o == limited_count($past(therm_i))); // R1

    AST_SEED_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        run_len == 2'd1 |-> sample_o == seed_word()); // R7

    generate
        if (2 * SAMPLE_W >= TAP_HI) begin : g_recur
            for (genvar b = 0; b < SAMPLE_W; b++) begin : g_bit
                AST_PAT_RECUR: assert property (@(posedge clk) disable iff (!rst_n)
                    run_len == 2'd3 |->
                    hist[2*SAMPLE_W+b] == (hist[2*SAMPLE_W+b-TAP_HI] ^ hist[2*SAMPLE_W+b-TAP_LO])); // R5
            end
        end
    endgenerate
endmodule

bind therm_prbs_encoder therm_prbs_encoder_chk #(
    .THERM_W  (THERM_W),
    .SAMPLE_W (SAMPLE_W),
    .LFSR_LEN (LFSR_LEN),
    .TAP_HI   (TAP_HI),
    .TAP_LO   (TAP_LO),
    .SEED     (SEED)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .therm_i      (therm_i),
    .pattern_en_i (pattern_en_i),
    .sample_o     (sample_o),
    .sample_vld_o (sample_vld_o)
);

// File: tb/therm_prbs_encoder_tb_top.sv
`timescale 1ns/1ps
module therm_prbs_encoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] therm = '0;
    logic        pat_en = 1'b0;
    logic [3:0]  sample;
    logic        vld;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [6:0]  mh;
    logic [3:0]  words [0:253];

    therm_prbs_encoder dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .therm_i      (therm),
        .pattern_en_i (pat_en),
        .sample_o     (sample),
        .sample_vld_o (vld)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] ones(input logic [14:0] v);
        int n = 0;
        for (int i = 0; i < 15; i++) n += int'(v[i]);
        return (n > 15) ? 4'd15 : 4'(n);
    endfunction

    // Model of the sequence: seven history bits, most recent in bit 0.
    function automatic logic [3:0] model_word();
        logic [3:0] w;
        for (int k = 0; k < 4; k++) begin
            w[k] = mh[6] ^ mh[5];
            mh   = {mh[5:0], w[k]};
        end
        return w;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R4 / R9: reset holds outputs at zero regardless of inputs.
        rst_n = 1'b0; therm = 15'h7FFF; pat_en = 1'b1;
        tick(); tick();
        check("R4 reset sample", sample, 4'd0);
        check("R4 reset valid", {3'd0, vld}, 4'd0);
        pat_en = 1'b0; therm = 15'h1234;
        tick();
        check("R9 inputs ignored in reset", sample, 4'd0);

        // R3 / R4: first edge out of reset gives valid data.
        rst_n = 1'b1; therm = 15'h00FF;
        tick();
        check("R4 valid after release", {3'd0, vld}, 4'd1);
        check("R3 first word latency", sample, 4'd8);

        // R1 / R3: every input vector, one per clock.
        for (int v = 0; v < 32768; v++) begin
            therm = 15'(v);
            tick();
            check("R1 R3 ones count", sample, ones(15'(v)));
        end

        // R2: bubbled codes.
        therm = 15'h005F; tick(); check("R2 bubble 005F", sample, 4'd6);
        therm = 15'h7FFE; tick(); check("R2 bubble 7FFE", sample, 4'd14);
        therm = 15'h7FFF; tick(); check("R1 full scale", sample, 4'd15);

        // R5 / R6 / R7: pattern run of two periods, therm kept changing.
        pat_en = 1'b1; mh = 7'h7F;
        for (int n = 0; n < 254; n++) begin
            therm = 15'(n * 37);
            tick();
            words[n] = sample;
            check("R5 R6 pattern word", sample, model_word());
        end
        check("R7 first word", words[0], 4'b0000);
        check("R7 second word", words[1], 4'b0100);
        for (int n = 0; n < 127; n++)
            check("R10 period 127", words[n + 127], words[n]);

        // R8: drop the enable, encoding resumes at once.
        pat_en = 1'b0; therm = 15'h0007;
        tick();
        check("R8 encode after disable", sample, 4'd3);
        pat_en = 1'b1;
        tick();
        check("R8 restart word 0", sample, 4'b0000);
        tick();
        check("R8 restart word 1", sample, 4'b0100);

        // R4 / R7: reset inside a run, enable held high.
        tick();
        rst_n = 1'b0;
        tick();
        check("R4 mid-run reset", sample, 4'd0);
        rst_n = 1'b1; mh = 7'h7F;
        for (int n = 0; n < 5; n++) begin
            tick();
            check("R7 seed after reset", sample, model_word());
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule